// File: doc/BRIEF.md
# Crate Timing and Calibration Sequencer

This block drives the timing lines of a crate of digitizer boards: a crate clock, a first-level trigger line and a trigger-reset line. It also drives a test-pulse line and a shared serial clock/data pair. The serial pair feeds a calibration DAC and a set of gain potentiometers. A small register port picks one of three operating modes. In pass-through mode the external trigger system's clock, trigger and trigger-reset are forwarded. In free-run mode only a locally divided clock goes out. In calibration mode the block makes its own clock and can run a calibration shot.

A calibration shot starts when the DAC code is written. The block shifts the code out MSB first and strobes the DAC load line. It then raises the test pulse and, after a programmed number of cycles, issues one synthetic trigger. In the same mode a write to the gain register shifts a shorter word to the potentiometers and ends with their own load strobe. A mode change cancels any shot in progress.

Top module: `crate_timing_ctrl`

## Requirements
- R1: After reset the mode is pass-through (code 0), the trigger delay register holds 64, and every output is low.
- R2: A write to address 0 selects the mode from data bits [1:0]: 0 pass-through, 1 calibration, 2 free-run. Code 3 is ignored and the mode stays as it was.
- R3: In pass-through mode `crate_clk`, `crate_l1` and `crate_l1_rst` equal `ext_clk`, `ext_l1` and `ext_l1_rst` sampled one clock earlier.
- R4: In calibration and free-run modes `crate_clk` is the internal clock. That clock starts low at reset and toggles every HALF_PER system clocks. `crate_l1_rst` is low in both modes. `crate_l1` is low in free-run mode and carries only the synthetic trigger in calibration mode.
- R5: A write to address 1 (DAC code) or address 3 (gain word) starts a sequence only in calibration mode with no sequence running. Any other such write is ignored.
- R6: A sequence shifts its word MSB first. Each bit takes two cycles, `ser_clk` low then high, with `ser_din` steady across both. A one-cycle load strobe follows with `ser_clk` low: `dac_ld` for a DAC code of DATA_W bits, `pot_ld` for the low POT_W bits of a gain word.
- R7: After a DAC load the test pulse is high for TP_W cycles, starting the cycle after `dac_ld`. A gain load produces no test pulse and no trigger.
- R8: The synthetic trigger is a one-cycle `crate_l1` high exactly D cycles after the test pulse rises. D is the delay register (address 2) as it stood when the DAC write started the shot. D = 0 puts the trigger on the pulse's first cycle.
- R9: A write to address 0 with a valid code different from the current mode aborts a running sequence. From the next cycle the serial, strobe, test-pulse and synthetic-trigger outputs are low. A rewrite of the current mode does not abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address (0 mode, 1 DAC code, 2 delay, 3 gain word) |
| cfg_wdata | input | DATA_W | Register write data |
| ext_clk | input | 1 | Clock from the external trigger system |
| ext_l1 | input | 1 | Trigger from the external trigger system |
| ext_l1_rst | input | 1 | Trigger reset from the external trigger system |
| crate_clk | output | 1 | Clock distributed to the crate |
| crate_l1 | output | 1 | Trigger distributed to the crate |
| crate_l1_rst | output | 1 | Trigger reset distributed to the crate |
| test_pulse | output | 1 | Calibration test pulse |
| ser_clk | output | 1 | Serial clock to DAC and potentiometers |
| ser_din | output | 1 | Serial data to DAC and potentiometers |
| dac_ld | output | 1 | DAC load strobe |
| pot_ld | output | 1 | Potentiometer load strobe |

## Verification
The bench aims at trigger delays shorter than the test pulse, including zero. A design that ended the shot at the trigger would cut the pulse short, and one that waited for the pulse to end would lose the trigger. It moves the delay register and writes further DAC codes in the middle of a shift. A design that did not latch the delay would fire at the wrong cycle, and one that took the second write would corrupt the serial stream. It aborts during the shift and during the pulse window, and it rewrites the current mode and writes code 3. A wrong abort rule shows up as a stray strobe or a truncated shot. Free-running external inputs expose a design that leaks them outside pass-through mode.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

   typedef enum logic [1:0] {
      MODE_PASS  = 2'd0,
      MODE_CAL   = 2'd1,
      MODE_FREE  = 2'd2
   } ctc_mode_e;

   localparam logic [1:0] REG_MODE  = 2'd0;
   localparam logic [1:0] REG_DAC   = 2'd1;
   localparam logic [1:0] REG_DELAY = 2'd2;
   localparam logic [1:0] REG_GAIN  = 2'd3;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_SHIFT = 2'd1,
      SQ_LOAD  = 2'd2,
      SQ_FIRE  = 2'd3
   } ctc_seq_e;

endpackage

// File: rtl/ctc_regs.sv
module ctc_regs
   import ctc_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int DLY_W   = 16,
   parameter int DLY_RST = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              seq_idle,
   output ctc_mode_e         mode_q,
   output logic [DLY_W-1:0]  dly_q,
   output logic              start_dac,
   output logic              start_pot,
   output logic              abort
);

   logic mode_ok;
   logic cal_free;

   assign mode_ok  = (wdata[1:0] != 2'd3);
   assign cal_free = (mode_q == MODE_CAL) && seq_idle;

   assign abort     = we && (addr == REG_MODE) && mode_ok && (wdata[1:0] != mode_q);
   assign start_dac = we && (addr == REG_DAC)  && cal_free;
   assign start_pot = we && (addr == REG_GAIN) && cal_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_PASS;
         dly_q  <= DLY_W'(DLY_RST);
      end else if (we) begin
         if (addr == REG_MODE && mode_ok)
            mode_q <= ctc_mode_e'(wdata[1:0]);
         if (addr == REG_DELAY)
            dly_q <= wdata[DLY_W-1:0];
      end
   end

endmodule

// File: rtl/ctc_clkgen.sv
module ctc_clkgen #(
   parameter int HALF_PER = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic gen_clk
);

   generate
      if (HALF_PER == 1) begin : g_toggle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gen_clk <= 1'b0;
            else        gen_clk <= ~gen_clk;
         end
      end else begin : g_count
         localparam int CW = $clog2(HALF_PER);
         localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt     <= '0;
               gen_clk <= 1'b0;
            end else if (cnt == LAST) begin
               cnt     <= '0;
               gen_clk <= ~gen_clk;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ctc_seq.sv
module ctc_seq
   import ctc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int POT_W  = 8,
   parameter int DLY_W  = 16,
   parameter int TP_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_dac,
   input  logic              start_pot,
   input  logic              abort,
   input  logic [DATA_W-1:0] word,
   input  logic [DLY_W-1:0]  dly,
   output logic              idle,
   output logic              ser_clk,
   output logic              ser_din,
   output logic              dac_ld,
   output logic              pot_ld,
   output logic              tp,
   output logic              l1
);

   localparam int BC_W  = $clog2(DATA_W + 1);
   localparam int CNT_W = DLY_W + 1;
   localparam logic [BC_W-1:0]  NB_DAC  = BC_W'(DATA_W);
   localparam logic [BC_W-1:0]  NB_POT  = BC_W'(POT_W);
   localparam logic [CNT_W-1:0] TP_LAST = CNT_W'(TP_W - 1);
   localparam logic [CNT_W-1:0] TP_LEN  = CNT_W'(TP_W);

   ctc_seq_e           st;
   logic               phase;
   logic               to_pot;
   logic [BC_W-1:0]    bitn;
   logic [BC_W-1:0]    nbits;
   logic [DATA_W-1:0]  sh;
   logic [CNT_W-1:0]   cnt;
   logic [DLY_W-1:0]   dly_l;
   logic [CNT_W-1:0]   dly_x;
   logic [DATA_W-1:0]  pot_aligned;

   assign dly_x = {1'b0, dly_l};

   generate
      if (POT_W == DATA_W) begin : g_pot_full
         assign pot_aligned = word;
      end else begin : g_pot_part
         assign pot_aligned = {word[POT_W-1:0], {(DATA_W-POT_W){1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         phase  <= 1'b0;
         to_pot <= 1'b0;
         bitn   <= '0;
         nbits  <= '0;
         sh     <= '0;
         cnt    <= '0;
         dly_l  <= '0;
      end else if (abort) begin
         st    <= SQ_IDLE;
         phase <= 1'b0;
      end else begin
         unique case (st)
            SQ_IDLE: begin
               phase <= 1'b0;
               bitn  <= '0;
               if (start_dac) begin
                  st     <= SQ_SHIFT;
                  sh     <= word;
                  nbits  <= NB_DAC;
                  to_pot <= 1'b0;
                  dly_l  <= dly;
               end else if (start_pot) begin
                  st     <= SQ_SHIFT;
                  sh     <= pot_aligned;
                  nbits  <= NB_POT;
                  to_pot <= 1'b1;
               end
            end
            SQ_SHIFT: begin
               phase <= ~phase;
               if (phase) begin
                  sh   <= sh << 1;
                  bitn <= bitn + BC_W'(1);
                  if (bitn == nbits - BC_W'(1))
                     st <= SQ_LOAD;
               end
            end
            SQ_LOAD: begin
               cnt <= '0;
               st  <= to_pot ? SQ_IDLE : SQ_FIRE;
            end
            SQ_FIRE: begin
               cnt <= cnt + CNT_W'(1);
               if (cnt >= dly_x && cnt >= TP_LAST)
                  st <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign idle    = (st == SQ_IDLE);
   assign ser_clk = (st == SQ_SHIFT) && phase;
   assign ser_din = (st == SQ_SHIFT) && sh[DATA_W-1];
   assign dac_ld  = (st == SQ_LOAD) && !to_pot;
   assign pot_ld  = (st == SQ_LOAD) && to_pot;
   assign tp      = (st == SQ_FIRE) && (cnt < TP_LEN);
   assign l1      = (st == SQ_FIRE) && (cnt == dly_x);

endmodule

// File: rtl/crate_timing_ctrl.sv
module crate_timing_ctrl
   import ctc_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int POT_W    = 8,
   parameter int DLY_W    = 16,
   parameter int DLY_RST  = 64,
   parameter int TP_W     = 4,
   parameter int HALF_PER = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              ext_clk,
   input  logic              ext_l1,
   input  logic              ext_l1_rst,
   output logic              crate_clk,
   output logic              crate_l1,
   output logic              crate_l1_rst,
   output logic              test_pulse,
   output logic              ser_clk,
   output logic              ser_din,
   output logic              dac_ld,
   output logic              pot_ld
);

   generate
      if (POT_W < 1 || POT_W > DATA_W) begin : g_bad_pot
         $error("POT_W must lie in 1..DATA_W");
      end
      if (DLY_W < 1 || DLY_W > DATA_W) begin : g_bad_dly
         $error("DLY_W must lie in 1..DATA_W");
      end
      if (TP_W < 1 || TP_W >= (1 << DLY_W)) begin : g_bad_tp
         $error("TP_W must be at least 1 and fit the delay counter");
      end
      if (DLY_RST < 0 || DLY_RST >= (1 << DLY_W)) begin : g_bad_rst
         $error("DLY_RST must fit DLY_W bits");
      end
      if (HALF_PER < 1) begin : g_bad_half
         $error("HALF_PER must be at least 1");
      end
   endgenerate

   ctc_mode_e        mode_q;
   logic [DLY_W-1:0] dly_q;
   logic             start_dac;
   logic             start_pot;
   logic             abort;
   logic             seq_idle;
   logic             seq_l1;
   logic             gen_clk;
   logic             ext_clk_q;
   logic             ext_l1_q;
   logic             ext_l1_rst_q;

   ctc_regs #(
      .DATA_W  (DATA_W),
      .DLY_W   (DLY_W),
      .DLY_RST (DLY_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .seq_idle  (seq_idle),
      .mode_q    (mode_q),
      .dly_q     (dly_q),
      .start_dac (start_dac),
      .start_pot (start_pot),
      .abort     (abort)
   );

   ctc_clkgen #(
      .HALF_PER (HALF_PER)
   ) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .gen_clk (gen_clk)
   );

   ctc_seq #(
      .DATA_W (DATA_W),
      .POT_W  (POT_W),
      .DLY_W  (DLY_W),
      .TP_W   (TP_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_dac (start_dac),
      .start_pot (start_pot),
      .abort     (abort),
      .word      (cfg_wdata),
      .dly       (dly_q),
      .idle      (seq_idle),
      .ser_clk   (ser_clk),
      .ser_din   (ser_din),
      .dac_ld    (dac_ld),
      .pot_ld    (pot_ld),
      .tp        (test_pulse),
      .l1        (seq_l1)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_clk_q    <= 1'b0;
         ext_l1_q     <= 1'b0;
         ext_l1_rst_q <= 1'b0;
      end else begin
         ext_clk_q    <= ext_clk;
         ext_l1_q     <= ext_l1;
         ext_l1_rst_q <= ext_l1_rst;
      end
   end

   always_comb begin
      crate_clk    = gen_clk;
      crate_l1     = 1'b0;
      crate_l1_rst = 1'b0;
      unique case (mode_q)
         MODE_PASS: begin
            crate_clk    = ext_clk_q;
            crate_l1     = ext_l1_q;
            crate_l1_rst = ext_l1_rst_q;
         end
         MODE_CAL:  crate_l1 = seq_l1;
         default:   crate_l1 = 1'b0;
      endcase
   end

endmodule

// File: rtl/ctc_chk.sv
module ctc_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic [1:0] cfg_addr,
   input logic [1:0] mode_wd,
   input logic [1:0] mode_q,
   input logic       ext_l1,
   input logic       crate_l1,
   input logic       crate_l1_rst,
   input logic       test_pulse,
   input logic       ser_clk,
   input logic       dac_ld,
   input logic       pot_ld
);

   logic past_ok;
   logic mode_wr;
   logic abort_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign mode_wr  = cfg_we && (cfg_addr == 2'd0);
   assign abort_wr = mode_wr && (mode_wd != 2'd3) && (mode_wd != mode_q);

   // R6: each load strobe lasts a single cycle
   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_ld || pot_ld) |=> !(dac_ld || pot_ld));

   // R7: the test pulse follows a DAC load unless a mode write intervenes
   assert_pulse_follows_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_ld && !mode_wr) |=> test_pulse);

   // R3: pass-through trigger is the external trigger one cycle late
   assert_pass_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && mode_q == 2'd0) |-> (crate_l1 == $past(ext_l1)));

   // R4: free-run mode keeps trigger, trigger reset and pulse low
   assert_free_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd2) |-> (!crate_l1 && !crate_l1_rst && !test_pulse));

   // R5: a test pulse exists only in calibration mode
   assert_pulse_in_cal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      test_pulse |-> (mode_q == 2'd1));

   // R9: an aborting mode write silences the sequencer next cycle
   assert_abort_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort_wr |=> (!test_pulse && !ser_clk && !dac_ld && !pot_ld));

endmodule

bind crate_timing_ctrl ctc_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_addr     (cfg_addr),
   .mode_wd      (cfg_wdata[1:0]),
   .mode_q       (mode_q),
   .ext_l1       (ext_l1),
   .crate_l1     (crate_l1),
   .crate_l1_rst (crate_l1_rst),
   .test_pulse   (test_pulse),
   .ser_clk      (ser_clk),
   .dac_ld       (dac_ld),
   .pot_ld       (pot_ld)
);

// File: tb/sim_crate_timing_ctrl.sv
module sim_crate_timing_ctrl;

   localparam int DW  = 16;
   localparam int PW  = 8;
   localparam int TPW = 4;
   localparam int HP  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_addr = 2'd0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          ext_clk = 1'b0;
   logic          ext_l1 = 1'b0;
   logic          ext_l1_rst = 1'b0;
   logic          crate_clk, crate_l1, crate_l1_rst, test_pulse;
   logic          ser_clk, ser_din, dac_ld, pot_ld;

   always #5 clk = ~clk;

   crate_timing_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .ext_clk(ext_clk), .ext_l1(ext_l1),
      .ext_l1_rst(ext_l1_rst), .crate_clk(crate_clk), .crate_l1(crate_l1),
      .crate_l1_rst(crate_l1_rst), .test_pulse(test_pulse), .ser_clk(ser_clk),
      .ser_din(ser_din), .dac_ld(dac_ld), .pot_ld(pot_ld)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   bit    ext_en = 1'b0;
   string tag = "R1";

   // reference model state; entry bits {sclk, din, dac_ld, pot_ld, pulse, trig}
   logic [5:0] q[$];
   logic [5:0] cur;
   bit         act;
   int         m_mode;
   int         m_dly;
   int         n_edge;
   logic       e_clk, e_l1, e_rst;

   task automatic push_dac(input logic [DW-1:0] w, input int d);
      int last;
      for (int k = DW - 1; k >= 0; k--) begin
         q.push_back({1'b0, w[k], 4'b0000});
         q.push_back({1'b1, w[k], 4'b0000});
      end
      q.push_back(6'b001000);
      last = (d > TPW - 1) ? d : TPW - 1;
      for (int c = 0; c <= last; c++)
         q.push_back({4'b0000, (c < TPW), (c == d)});
   endtask

   task automatic push_pot(input logic [DW-1:0] w);
      for (int k = PW - 1; k >= 0; k--) begin
         q.push_back({1'b0, w[k], 4'b0000});
         q.push_back({1'b1, w[k], 4'b0000});
      end
      q.push_back(6'b000100);
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         cur = '0; act = 1'b0; m_mode = 0; m_dly = 64; n_edge = 0;
         e_clk = 1'b0; e_l1 = 1'b0; e_rst = 1'b0;
      end else begin
         n_edge++;
         e_clk = ext_clk; e_l1 = ext_l1; e_rst = ext_l1_rst;
         if (cfg_we) begin
            case (cfg_addr)
               2'd0: if (cfg_wdata[1:0] != 2'd3) begin
                  if (int'(cfg_wdata[1:0]) != m_mode) begin
                     q.delete(); act = 1'b0; cur = '0;
                  end
                  m_mode = int'(cfg_wdata[1:0]);
               end
               2'd1: if (m_mode == 1 && !act) push_dac(cfg_wdata, m_dly);
               2'd2: m_dly = int'(cfg_wdata);
               default: if (m_mode == 1 && !act) push_pot(cfg_wdata);
            endcase
         end
         if (q.size() > 0) begin cur = q.pop_front(); act = 1'b1; end
         else begin cur = '0; act = 1'b0; end
      end
   end

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      logic [7:0] got, exp;
      logic g;
      if (rst_n && !done) begin
         g = 1'(((n_edge / HP) % 2));
         exp[7] = (m_mode == 0) ? e_clk : g;
         exp[6] = (m_mode == 0) ? e_l1 : ((m_mode == 1) ? cur[0] : 1'b0);
         exp[5] = (m_mode == 0) ? e_rst : 1'b0;
         exp[4] = cur[1];
         exp[3] = cur[5];
         exp[2] = cur[4];
         exp[1] = cur[3];
         exp[0] = cur[2];
         got = {crate_clk, crate_l1, crate_l1_rst, test_pulse,
                ser_clk, ser_din, dac_ld, pot_ld};
         n_cmp++;
         if (got !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: outputs %b expected %b", tag, cyc, got, exp);
         end
      end
   end

   always @(negedge clk) begin
      if (ext_en) begin
         ext_clk    <= ~ext_clk;
         ext_l1     <= 1'($urandom_range(0, 1));
         ext_l1_rst <= 1'($urandom_range(0, 1));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cyc);
         report();
      end
   end

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R1: outputs low while reset is held
      repeat (3) begin
         @(negedge clk);
         n_cmp++;
         if ({crate_clk, crate_l1, crate_l1_rst, test_pulse, ser_clk, ser_din, dac_ld, pot_ld} !== 8'h00) begin
            n_bad++;
            $display("FAIL R1 reset: outputs %b expected 00000000",
               {crate_clk, crate_l1, crate_l1_rst, test_pulse, ser_clk, ser_din, dac_ld, pot_ld});
         end
      end
      rst_n = 1'b1;
      idle(5);
      tag = "R3"; ext_en = 1'b1; idle(40);
      tag = "R2"; wr(2'd0, 16'h0003); idle(10);
      tag = "R5"; wr(2'd1, 16'hFFFF); wr(2'd3, 16'h00FF); idle(40);
      tag = "R4"; wr(2'd0, 16'h0002); idle(30);
      wr(2'd1, 16'h1357); idle(40);
      // R1 default delay 64 exercised by this shot, R6 framing
      tag = "R6"; wr(2'd0, 16'h0001); wr(2'd1, 16'hA5C3); idle(120);
      tag = "R7"; wr(2'd2, 16'd2); wr(2'd1, 16'h8001); idle(50);
      tag = "R8"; wr(2'd2, 16'd0); wr(2'd1, 16'h7FFE); idle(50);
      tag = "R5"; wr(2'd2, 16'd10); wr(2'd1, 16'h1234); idle(6);
      wr(2'd1, 16'hFFFF); wr(2'd3, 16'h00AA);
      tag = "R8"; wr(2'd2, 16'd30); idle(80);
      tag = "R9"; wr(2'd3, 16'h005A); idle(30);
      wr(2'd3, 16'h01C3); idle(30);
      tag = "R9"; wr(2'd1, 16'hC0DE); idle(10);
      wr(2'd0, 16'h0002); idle(20);
      wr(2'd0, 16'h0001); wr(2'd2, 16'd40); wr(2'd1, 16'h0F0F); idle(38);
      wr(2'd0, 16'h0000); idle(20);
      wr(2'd0, 16'h0001); wr(2'd1, 16'h3C3C); idle(5);
      wr(2'd0, 16'h0001); wr(2'd0, 16'h0003); idle(100);
      wr(2'd3, 16'h00F0); idle(4);
      wr(2'd0, 16'h0002); idle(30);
      done = 1'b1;
      report();
   end

endmodule